// File: doc/BRIEF.md
# Endian-Selectable Bus-Matching Width Converter

This block sits between a 36-bit long-word port and a narrow port that may be 9, 18 or 36 bits wide. It has two independent paths. The unpack path takes a long word from the wide side and hands it to the narrow side as a sequence of pieces. The pack path collects pieces from the narrow side and presents each completed long word on the wide side. Every data port uses a valid/ready handshake, and a transfer happens on any rising clock edge where both valid and ready are high.

The piece order is set by a byte-order bit. While the synchronous active-low reset is held, the bit is captured from `endian_sel`. It keeps that value until the next reset. In big-endian order the most significant piece leads in both directions. In little-endian order the least significant piece leads. When the narrow port is full width, the byte-order bit has no effect and data passes through unchanged. The bus size comes from a static select.

Top module: `busmatch_conv`

## Requirements
- R1: One clock after a cycle with `rst_n` low, `n_out_valid` and `w_out_valid` are low, and `w_in_ready` and `n_in_ready` are high.
- R2: The byte-order bit takes the value of `endian_sel` on the last clock edge with `rst_n` low. Changing `endian_sel` while `rst_n` is high has no effect on the piece order.
- R3: Unpack, big-endian (`endian_sel`=1 at reset): for a long word, the first piece on `n_out_data` is its most significant piece and the last is its least significant piece.
- R4: Unpack, little-endian (`endian_sel`=0 at reset): for a long word, the first piece on `n_out_data` is its least significant piece and the last is its most significant piece.
- R5: Pack, big-endian: the first piece accepted goes to the most significant position of the long word, and later pieces fill the positions below it in order.
- R6: Pack, little-endian: the first piece accepted goes to bits [pw-1:0], and later pieces fill the positions above it in order. Here pw is the piece width.
- R7: `bus_size` encoding: 2'b00 is 36-bit, 2'b01 is 18-bit (two pieces per long word), 2'b10 is 9-bit (four pieces per long word), and 2'b11 behaves as 36-bit. At 36-bit, each long word passes through whole in both directions, whatever the byte-order bit is.
- R8: A piece on `n_out_data` occupies bits [pw-1:0], and the bits above are zero. From `n_in_data`, only bits [pw-1:0] are used.
- R9: While `n_out_valid` is high and `n_out_ready` is low, `n_out_data` and `n_out_valid` stay stable and `w_in_ready` is low. A new long word is accepted no earlier than the cycle in which the last piece of the current one is taken.
- R10: `w_out_valid` rises only after every piece of a long word has been accepted. While `w_out_valid` is high and `w_out_ready` is low, `w_out_data` is stable and `n_in_ready` is low.
- R11: Pieces of a partly packed long word that are present at reset are discarded. The first long word after reset is built only from pieces accepted after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; byte order captured while low |
| bus_size | input | 2 | Narrow port size select (static) |
| endian_sel | input | 1 | Byte-order select, 1 = big-endian |
| w_in_valid | input | 1 | Long word offered to unpack path |
| w_in_ready | output | 1 | Unpack path can take a long word |
| w_in_data | input | 36 | Long word to unpack |
| n_out_valid | output | 1 | Piece available on narrow output |
| n_out_ready | input | 1 | Narrow consumer takes the piece |
| n_out_data | output | 36 | Piece, right-aligned |
| n_in_valid | input | 1 | Piece offered to pack path |
| n_in_ready | output | 1 | Pack path can take a piece |
| n_in_data | input | 36 | Piece, right-aligned |
| w_out_valid | output | 1 | Assembled long word available |
| w_out_ready | input | 1 | Wide consumer takes the long word |
| w_out_data | output | 36 | Assembled long word |

## Verification
Each path has one cycle in which two events coincide. In the unpack path, the handoff of the last piece can fall in the same cycle as the loading of the next long word. In the pack path, the draining of a finished long word can fall in the same cycle as the acceptance of the first piece of the next one. The bench drives ready and valid on each side with different periodic gaps, so both overlaps occur many times for every combination of bus size and byte order. Every piece and every long word is compared with an arithmetic model of the order. A refill that comes too early, or an overwrite that comes too late, shows up as a wrong or duplicated piece. Held outputs under backpressure are checked cycle by cycle.

// File: rtl/busmatch_pkg.sv
package busmatch_pkg;
   typedef enum logic [1:0] {
      BM_W36  = 2'b00,
      BM_W18  = 2'b01,
      BM_W9   = 2'b10,
      BM_WRSV = 2'b11
   } bm_size_e;
endpackage

// File: rtl/busmatch_lane_map.sv
// Maps a piece index to a bit offset and a lane mask inside the long word.
module busmatch_lane_map
   import busmatch_pkg::*;
#(
   parameter int LONG_W = 36,
   parameter int CNT_W  = 2,
   parameter int SH_W   = $clog2(LONG_W)
) (
   input  bm_size_e            size_i,
   input  logic                big_i,
   input  logic [CNT_W-1:0]    idx_i,
   output logic [SH_W-1:0]     shift_o,
   output logic [LONG_W-1:0]   mask_o,
   output logic                last_o
);
   localparam int HALF_W = LONG_W / 2;
   localparam int QTR_W  = LONG_W / 4;
   localparam logic [SH_W-1:0]   HALF_SH   = SH_W'(HALF_W);
   localparam logic [SH_W-1:0]   QTR_SH    = SH_W'(QTR_W);
   localparam logic [LONG_W-1:0] HALF_MASK = {{(LONG_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
   localparam logic [LONG_W-1:0] QTR_MASK  = {{(LONG_W-QTR_W){1'b0}}, {QTR_W{1'b1}}};

   logic [CNT_W-1:0]  max_idx;
   logic [CNT_W-1:0]  lane;
   logic [LONG_W-1:0] base_mask;

   always_comb begin
      unique case (size_i)
         BM_W18:  begin max_idx = CNT_W'(1); base_mask = HALF_MASK; end
         BM_W9:   begin max_idx = CNT_W'(3); base_mask = QTR_MASK;  end
         default: begin max_idx = '0;       base_mask = '1;        end
      endcase
      lane = big_i ? (max_idx - idx_i) : idx_i;
      unique case (size_i)
         BM_W18:  shift_o = lane[0] ? HALF_SH : '0;
         BM_W9:   shift_o = SH_W'(lane) * QTR_SH;
         default: shift_o = '0;
      endcase
      mask_o = base_mask << shift_o;
      last_o = (idx_i == max_idx);
   end
endmodule

// File: rtl/busmatch_unpack.sv
// Splits long words into ordered pieces.
module busmatch_unpack
   import busmatch_pkg::*;
#(
   parameter int LONG_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bm_size_e          size_i,
   input  logic              big_i,
   input  logic              w_valid_i,
   output logic              w_ready_o,
   input  logic [LONG_W-1:0] w_data_i,
   output logic              n_valid_o,
   input  logic              n_ready_i,
   output logic [LONG_W-1:0] n_data_o
);
   localparam int CNT_W = 2;
   localparam int SH_W  = $clog2(LONG_W);

   logic [LONG_W-1:0] word_q;
   logic [CNT_W-1:0]  idx_q;
   logic              busy_q;
   logic [SH_W-1:0]   shift;
   logic [LONG_W-1:0] mask;
   logic              last;
   logic              take, done, load;

   busmatch_lane_map #(.LONG_W(LONG_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_map (
      .size_i (size_i),
      .big_i  (big_i),
      .idx_i  (idx_q),
      .shift_o(shift),
      .mask_o (mask),
      .last_o (last)
   );

   assign take      = busy_q && n_ready_i;
   assign done      = take && last;
   assign w_ready_o = !busy_q || done;
   assign load      = w_valid_i && w_ready_o;
   assign n_valid_o = busy_q;
   assign n_data_o  = (word_q & mask) >> shift;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         idx_q  <= '0;
         busy_q <= 1'b0;
      end else if (load) begin
         word_q <= w_data_i;
         idx_q  <= '0;
         busy_q <= 1'b1;
      end else if (done) begin
         idx_q  <= '0;
         busy_q <= 1'b0;
      end else if (take) begin
         idx_q  <= idx_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/busmatch_pack.sv
// Assembles ordered pieces into long words; the accumulator is the output register.
module busmatch_pack
   import busmatch_pkg::*;
#(
   parameter int LONG_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bm_size_e          size_i,
   input  logic              big_i,
   input  logic              n_valid_i,
   output logic              n_ready_o,
   input  logic [LONG_W-1:0] n_data_i,
   output logic              w_valid_o,
   input  logic              w_ready_i,
   output logic [LONG_W-1:0] w_data_o
);
   localparam int CNT_W = 2;
   localparam int SH_W  = $clog2(LONG_W);

   logic [LONG_W-1:0] acc_q;
   logic [CNT_W-1:0]  idx_q;
   logic              full_q;
   logic [SH_W-1:0]   shift;
   logic [LONG_W-1:0] mask;
   logic              last;
   logic              accept, drain;

   busmatch_lane_map #(.LONG_W(LONG_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_map (
      .size_i (size_i),
      .big_i  (big_i),
      .idx_i  (idx_q),
      .shift_o(shift),
      .mask_o (mask),
      .last_o (last)
   );

   assign n_ready_o = !full_q || w_ready_i;
   assign accept    = n_valid_i && n_ready_o;
   assign drain     = full_q && w_ready_i;
   assign w_valid_o = full_q;
   assign w_data_o  = acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         idx_q  <= '0;
         full_q <= 1'b0;
      end else begin
         if (drain) full_q <= 1'b0;
         if (accept) begin
            acc_q <= (acc_q & ~mask) | ((n_data_i << shift) & mask);
            if (last) begin
               full_q <= 1'b1;
               idx_q  <= '0;
            end else begin
               idx_q  <= idx_q + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/busmatch_conv.sv
module busmatch_conv
   import busmatch_pkg::*;
#(
   parameter int LONG_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_size,
   input  logic              endian_sel,
   input  logic              w_in_valid,
   output logic              w_in_ready,
   input  logic [LONG_W-1:0] w_in_data,
   output logic              n_out_valid,
   input  logic              n_out_ready,
   output logic [LONG_W-1:0] n_out_data,
   input  logic              n_in_valid,
   output logic              n_in_ready,
   input  logic [LONG_W-1:0] n_in_data,
   output logic              w_out_valid,
   input  logic              w_out_ready,
   output logic [LONG_W-1:0] w_out_data
);
   if (LONG_W < 4 || (LONG_W % 4) != 0) begin : g_bad_width
      $error("busmatch_conv: LONG_W must be a positive multiple of 4");
   end

   bm_size_e size;
   logic     endian_q;

   assign size = bm_size_e'(bus_size);

   // byte order follows the select while reset is held, then stays frozen
   always_ff @(posedge clk) begin
      if (!rst_n) endian_q <= endian_sel;
   end

   busmatch_unpack #(.LONG_W(LONG_W)) u_unpack (
      .clk      (clk),
      .rst_n    (rst_n),
      .size_i   (size),
      .big_i    (endian_q),
      .w_valid_i(w_in_valid),
      .w_ready_o(w_in_ready),
      .w_data_i (w_in_data),
      .n_valid_o(n_out_valid),
      .n_ready_i(n_out_ready),
      .n_data_o (n_out_data)
   );

   busmatch_pack #(.LONG_W(LONG_W)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .size_i   (size),
      .big_i    (endian_q),
      .n_valid_i(n_in_valid),
      .n_ready_o(n_in_ready),
      .n_data_i (n_in_data),
      .w_valid_o(w_out_valid),
      .w_ready_i(w_out_ready),
      .w_data_o (w_out_data)
   );
endmodule

// File: rtl/busmatch_conv_chk.sv
module busmatch_conv_chk #(
   parameter int LONG_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_size,
   input logic              endian_q,
   input logic              w_in_ready,
   input logic              n_out_valid,
   input logic              n_out_ready,
   input logic [LONG_W-1:0] n_out_data,
   input logic              n_in_ready,
   input logic              w_out_valid,
   input logic              w_out_ready,
   input logic [LONG_W-1:0] w_out_data
);
   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!n_out_valid && !w_out_valid));

   a_r2_order_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(endian_q));

   a_r8_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (n_out_valid && bus_size == 2'b01) |-> (n_out_data[LONG_W-1:LONG_W/2] == '0));

   a_r8_qtr_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (n_out_valid && bus_size == 2'b10) |-> (n_out_data[LONG_W-1:LONG_W/4] == '0));

   a_r9_piece_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (n_out_valid && !n_out_ready) |=> (n_out_valid && $stable(n_out_data)));

   a_r9_no_early_load: assert property (@(posedge clk) disable iff (!rst_n)
      (n_out_valid && !n_out_ready) |-> !w_in_ready);

   a_r10_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (w_out_valid && !w_out_ready) |=> (w_out_valid && $stable(w_out_data)));

   a_r10_pack_block: assert property (@(posedge clk) disable iff (!rst_n)
      (w_out_valid && !w_out_ready) |-> !n_in_ready);
endmodule

bind busmatch_conv busmatch_conv_chk #(.LONG_W(LONG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_size   (bus_size),
   .endian_q   (endian_q),
   .w_in_ready (w_in_ready),
   .n_out_valid(n_out_valid),
   .n_out_ready(n_out_ready),
   .n_out_data (n_out_data),
   .n_in_ready (n_in_ready),
   .w_out_valid(w_out_valid),
   .w_out_ready(w_out_ready),
   .w_out_data (w_out_data)
);

// File: tb/busmatch_conv_bench.sv
module busmatch_conv_bench;
   localparam int LW = 36;
   localparam int NW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    bus_size = 2'b00;
   logic          endian_sel = 1'b0;
   logic          w_in_valid = 1'b0, n_out_ready = 1'b0, n_in_valid = 1'b0, w_out_ready = 1'b0;
   logic [LW-1:0] w_in_data = '0, n_in_data = '0;
   logic          w_in_ready, n_out_valid, n_in_ready, w_out_valid;
   logic [LW-1:0] n_out_data, w_out_data;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   busmatch_conv #(.LONG_W(LW)) u_busmatch_conv (
      .clk(clk), .rst_n(rst_n), .bus_size(bus_size), .endian_sel(endian_sel),
      .w_in_valid(w_in_valid), .w_in_ready(w_in_ready), .w_in_data(w_in_data),
      .n_out_valid(n_out_valid), .n_out_ready(n_out_ready), .n_out_data(n_out_data),
      .n_in_valid(n_in_valid), .n_in_ready(n_in_ready), .n_in_data(n_in_data),
      .w_out_valid(w_out_valid), .w_out_ready(w_out_ready), .w_out_data(w_out_data)
   );

   task automatic chk(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [LW-1:0] mkword(int i);
      return 36'h9_8765_4321 ^ (36'(i) * 36'h1_1357_9BDF);
   endfunction

   // pieces carry junk above the piece width (R8)
   function automatic logic [LW-1:0] mkpiece(int j);
      return 36'hF_0F0F_0F00 ^ (36'(j) * 36'h0_2468_ACE1);
   endfunction

   function automatic int npieces(logic [1:0] s);
      return (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 1;
   endfunction

   function automatic logic [LW-1:0] pmask(int pw);
      logic [LW:0] m;
      m = (37'd1 << pw) - 37'd1;
      return m[LW-1:0];
   endfunction

   function automatic logic [LW-1:0] exp_piece(logic [LW-1:0] w, logic [1:0] s, bit big, int k);
      int np, pw, lane;
      np = npieces(s); pw = LW / np;
      lane = big ? (np - 1 - k) : k;
      return (w >> (lane * pw)) & pmask(pw);
   endfunction

   function automatic logic [LW-1:0] exp_word(int base, logic [1:0] s, bit big);
      int np, pw, lane;
      logic [LW-1:0] w;
      np = npieces(s); pw = LW / np; w = '0;
      for (int k = 0; k < np; k++) begin
         lane = big ? (np - 1 - k) : k;
         w |= (mkpiece(base + k) & pmask(pw)) << (lane * pw);
      end
      return w;
   endfunction

   function automatic string tag(logic [1:0] s, bit big, bit pack);
      if (npieces(s) == 1) return "R7";
      if (!pack) return big ? "R3/R8" : "R4/R8";
      return big ? "R5/R8" : "R6/R8";
   endfunction

   task automatic do_reset(bit big);
      rst_n = 1'b0; endian_sel = big;
      w_in_valid = 1'b0; n_in_valid = 1'b0; n_out_ready = 1'b0; w_out_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 n_out_valid", 36'(n_out_valid), 36'd0);
      chk("R1 w_out_valid", 36'(w_out_valid), 36'd0);
      chk("R1 w_in_ready", 36'(w_in_ready), 36'd1);
      chk("R1 n_in_ready", 36'(n_in_ready), 36'd1);
      rst_n = 1'b1;
      @(negedge clk);
      endian_sel = ~big;   // R2: must not change the order
   endtask

   task automatic run_cfg(logic [1:0] s, bit big);
      int np, wi, pi, po, wo, cyc;
      bit nh, wh;
      logic [LW-1:0] nhd, whd;
      bus_size = s;
      do_reset(big);
      np = npieces(s);
      wi = 0; pi = 0; po = 0; wo = 0; cyc = 0; nh = 0; wh = 0; nhd = '0; whd = '0;
      while ((po < NW * np || wo < NW) && cyc < 3000) begin
         @(negedge clk);
         if (nh) begin
            chk("R9 piece valid held", 36'(n_out_valid), 36'd1);
            chk("R9 piece data held", n_out_data, nhd);
         end
         if (wh) begin
            chk("R10 word valid held", 36'(w_out_valid), 36'd1);
            chk("R10 word data held", w_out_data, whd);
         end
         n_out_ready = (cyc % 3) != 1;
         w_out_ready = (cyc % 4) != 2;
         w_in_valid  = (wi < NW) && ((cyc % 5) != 3);
         w_in_data   = mkword(wi);
         n_in_valid  = (pi < NW * np) && ((cyc % 7) != 4);
         n_in_data   = mkpiece(pi);
         #1;
         if (n_out_valid && n_out_ready) begin
            chk($sformatf("%s R2 unpack s=%0d big=%0d", tag(s, big, 0), s, big),
                n_out_data, exp_piece(mkword(po / np), s, big, po % np));
            po++;
         end
         if (w_out_valid && w_out_ready) begin
            chk($sformatf("%s R2 pack s=%0d big=%0d", tag(s, big, 1), s, big),
                w_out_data, exp_word(wo * np, s, big));
            wo++;
            chk("R10 word before all pieces", 36'((wo * np) <= pi), 36'd1);
         end
         if (n_out_valid && !n_out_ready)
            chk("R9 w_in_ready while piece pending", 36'(w_in_ready), 36'd0);
         if (w_out_valid && !w_out_ready)
            chk("R10 n_in_ready while word pending", 36'(n_in_ready), 36'd0);
         nh = n_out_valid && !n_out_ready; nhd = n_out_data;
         wh = w_out_valid && !w_out_ready; whd = w_out_data;
         if (w_in_valid && w_in_ready) wi++;
         if (n_in_valid && n_in_ready) pi++;
         cyc++;
      end
      if (cyc >= 3000) chk("timeout run_cfg", 36'(cyc), 36'd0);
      @(negedge clk);
      w_in_valid = 1'b0; n_in_valid = 1'b0;
   endtask

   task automatic send_pieces(int base, int cnt);
      int sent;
      sent = 0;
      while (sent < cnt) begin
         @(negedge clk);
         n_in_valid = 1'b1; n_in_data = mkpiece(base + sent);
         #1;
         if (n_in_ready) sent++;
      end
      @(negedge clk);
      n_in_valid = 1'b0;
   endtask

   task automatic partial_discard();
      int waitc;
      bus_size = 2'b10;
      do_reset(1'b0);
      w_out_ready = 1'b0;
      send_pieces(50, 2);
      do_reset(1'b0);   // R11: two leftover pieces must vanish
      w_out_ready = 1'b0;
      send_pieces(100, 4);
      waitc = 0;
      while (!w_out_valid && waitc < 20) begin @(negedge clk); waitc++; end
      chk("R11 word after reset", w_out_data, exp_word(100, 2'b10, 1'b0));
      chk("R11 valid after reset", 36'(w_out_valid), 36'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int s = 0; s < 4; s++) begin
         for (int b = 0; b < 2; b++) begin
            run_cfg(2'(s), b[0]);
         end
      end
      partial_discard();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule